// File: doc/BRIEF.md
# Receiver Tick Generator and Enable Sequencer

This block runs on the receiver's crystal-oscillator clock. It produces the two timing strobes that the rest of the digital receive path uses. The base tick comes from dividing the oscillator clock by one of two ratios, and a mode input picks the ratio. The extended tick is a power-of-two multiple of the base tick, and a two-bit baud-rate range input sets the multiple. Both strobes are one cycle wide and are enables in the oscillator domain, not derived clocks.

The same block turns the enable input into a session. While enable is low the receiver sleeps. Once enable goes high, a start-up interval runs first. Its length depends on the range and is counted in oscillator cycles, so that an interval with a half base tick is exact. After start-up the block waits for the first falling edge of the demodulated data. On that edge it opens a gate that lets the downstream data path drive its output. The mode and the range are captured when a session starts, and they hold until enable drops.

Top module: `rxtick_seq`

## Requirements
- R1: While the session state is sleep (state code 0), base_tick, ext_tick and data_gate stay low, whatever demod_in, mode_sel and rate_sel do.
- R2: The first base_tick of a session comes DIV cycles after entry into start-up, and later ones come every DIV cycles. DIV is 10 when the captured mode_sel is 0 and 14 when it is 1. The cycle in which state first reads 1 counts as cycle 1.
- R3: ext_tick coincides with every M-th base_tick, counted from the session start, with M = 8, 4, 2, 1 for range 0, 1, 2, 3. ext_tick is never high without base_tick.
- R4: The range value is rate_sel[1]*2 + rate_sel[0], so rate_sel[1] is the most significant bit.
- R5: Start-up (state code 1) lasts exactly H*DIV/2 cycles, with H = 1793, 1025, 1025, 641 half base ticks for range 0 to 3. That gives 8965 cycles for range 0 with DIV 10 and 12551 cycles with DIV 14. After start-up the state reads 2 (armed), and the gate stays closed.
- R6: In the armed state, a falling edge of demod_in opens data_gate and sets state code 3. A falling edge is a high sample followed by a low sample at successive clock edges. The gate and the state change one cycle after the low sample.
- R7: Once data_gate is open, it stays open for any demod_in activity for as long as enable_in stays high.
- R8: enable_in sampled low sends the state to sleep on that same clock edge and closes the gate. A new session restarts every counter, so its first base_tick again comes DIV cycles after entry.
- R9: Changes to mode_sel and rate_sel during an active session have no effect on tick spacing or on start-up length.
- R10: A falling edge of demod_in during start-up does not open the gate. The block still enters the armed state with data_gate low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Base divide ratio select: 0 selects the low ratio, 1 the high ratio |
| rate_sel | input | 2 | Baud-rate range; bit 1 is the MSB |
| enable_in | input | 1 | High requests an active session; low means sleep |
| demod_in | input | 1 | Demodulated data, used for edge alignment |
| base_tick | output | 1 | One-cycle base timing strobe |
| ext_tick | output | 1 | One-cycle extended timing strobe |
| state_o | output | 2 | Session state: 0 sleep, 1 start-up, 2 armed, 3 data open |
| data_gate | output | 1 | High when the downstream data path may drive its output |

## Verification
All state and counter registers update on the clock edge that samples their inputs. A state change caused by enable_in or demod_in is therefore visible in the cycle right after that edge. The bench drives inputs and reads outputs on the falling clock edge, and it numbers the cycles of a session from the first cycle in which the state reads start-up. Against that numbering, base ticks are due at cycle DIV·n and extended ticks at DIV·M·n. The armed code is due in cycle H·DIV/2 + 1. The open gate is due in the cycle after the low demod sample. The bench compares every cycle of each session with these positions.

// File: rtl/rxtick_pkg.sv
package rxtick_pkg;

   localparam int unsigned RATE_W = 2;
   localparam int unsigned RATE_N = 1 << RATE_W;

   typedef enum logic [1:0] {
      ST_SLEEP = 2'd0,
      ST_START = 2'd1,
      ST_ARMED = 2'd2,
      ST_OPEN  = 2'd3
   } seq_state_t;

   // Oscillator cycles in a start-up interval given in half base ticks.
   function automatic int unsigned stup_cycles(input int unsigned halves,
                                               input int unsigned div);
      return (halves * div) / 2;
   endfunction

endpackage

// File: rtl/rxtick_base_div.sv
module rxtick_base_div #(
   parameter int unsigned DIV_LO = 10,
   parameter int unsigned DIV_HI = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic sel_hi,
   output logic tick
);
   localparam int unsigned DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
   localparam int unsigned CNT_W   = $clog2(DIV_MAX);

   if (DIV_LO < 2 || DIV_HI < 2) begin : g_bad_div
      $error("rxtick_base_div: both ratios must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   if (DIV_LO == DIV_HI) begin : g_single
      assign last = CNT_W'(DIV_LO - 1);
   end else begin : g_dual
      assign last = sel_hi ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt == last) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = run && (cnt == last);

endmodule

// File: rtl/rxtick_ext_div.sv
module rxtick_ext_div
   import rxtick_pkg::*;
#(
   parameter int unsigned LOG_MAX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   input  logic              base_tick,
   output logic              tick
);
   if (LOG_MAX < RATE_N - 1) begin : g_bad_log
      $error("rxtick_ext_div: LOG_MAX must cover the highest range");
   end

   if (LOG_MAX == 0) begin : g_pass
      assign tick = base_tick;
   end else begin : g_count
      localparam int unsigned ECNT_W = LOG_MAX;

      logic [ECNT_W-1:0] ecnt;
      logic [ECNT_W-1:0] last;
      logic [ECNT_W:0]   mult;

      // Multiple of the base tick: 2^(LOG_MAX - range).
      always_comb begin
         mult = (ECNT_W+1)'(1) << (LOG_MAX - 32'(rate));
         last = ECNT_W'(mult - 1'b1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ecnt <= '0;
         end else if (!run) begin
            ecnt <= '0;
         end else if (base_tick) begin
            if (ecnt == last) begin
               ecnt <= '0;
            end else begin
               ecnt <= ecnt + 1'b1;
            end
         end
      end

      assign tick = base_tick && (ecnt == last);
   end

endmodule

// File: rtl/rxtick_seq_fsm.sv
module rxtick_seq_fsm
   import rxtick_pkg::*;
#(
   parameter int unsigned DIV_LO = 10,
   parameter int unsigned DIV_HI = 14,
   parameter int unsigned STUP_HALVES [RATE_N] = '{1793, 1025, 1025, 641}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_in,
   input  logic              demod_in,
   input  logic              mode_sel,
   input  logic [RATE_W-1:0] rate_sel,
   output seq_state_t        state,
   output logic              run,
   output logic              cfg_mode,
   output logic [RATE_W-1:0] cfg_rate
);
   function automatic int unsigned max_cycles();
      int unsigned m;
      m = 1;
      for (int r = 0; r < int'(RATE_N); r++) begin
         if (stup_cycles(STUP_HALVES[r], DIV_LO) > m) m = stup_cycles(STUP_HALVES[r], DIV_LO);
         if (stup_cycles(STUP_HALVES[r], DIV_HI) > m) m = stup_cycles(STUP_HALVES[r], DIV_HI);
      end
      return m;
   endfunction

   localparam int unsigned STUP_MAX = max_cycles();
   localparam int unsigned STUP_W   = $clog2(STUP_MAX + 1);

   if ((DIV_LO % 2) != 0 || (DIV_HI % 2) != 0) begin : g_bad_even
      $error("rxtick_seq_fsm: divide ratios must be even for half-tick start-up");
   end

   logic [STUP_W-1:0] lim_lo [RATE_N];
   logic [STUP_W-1:0] lim_hi [RATE_N];

   for (genvar r = 0; r < int'(RATE_N); r++) begin : g_lim
      localparam int unsigned C_LO = stup_cycles(STUP_HALVES[r], DIV_LO);
      localparam int unsigned C_HI = stup_cycles(STUP_HALVES[r], DIV_HI);
      if (C_LO < 1 || C_HI < 1) begin : g_bad_lim
         $error("rxtick_seq_fsm: start-up length must be at least one cycle");
      end
      assign lim_lo[r] = STUP_W'(C_LO);
      assign lim_hi[r] = STUP_W'(C_HI);
   end

   seq_state_t        nxt;
   logic [STUP_W-1:0] scnt;
   logic [STUP_W-1:0] limit;
   logic              demod_q;
   logic              fall;

   assign limit = cfg_mode ? lim_hi[cfg_rate] : lim_lo[cfg_rate];
   assign fall  = demod_q && !demod_in;

   always_comb begin
      nxt = state;
      if (!enable_in) begin
         nxt = ST_SLEEP;
      end else begin
         unique case (state)
            ST_SLEEP: nxt = ST_START;
            ST_START: if (scnt == limit - 1'b1) nxt = ST_ARMED;
            ST_ARMED: if (fall) nxt = ST_OPEN;
            ST_OPEN:  nxt = ST_OPEN;
            default:  nxt = ST_SLEEP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_SLEEP;
         scnt     <= '0;
         demod_q  <= 1'b0;
         cfg_mode <= 1'b0;
         cfg_rate <= '0;
      end else begin
         state   <= nxt;
         demod_q <= demod_in;
         if (state == ST_START && nxt == ST_START) begin
            scnt <= scnt + 1'b1;
         end else begin
            scnt <= '0;
         end
         if (state == ST_SLEEP) begin
            cfg_mode <= mode_sel;
            cfg_rate <= rate_sel;
         end
      end
   end

   assign run = (state != ST_SLEEP);

endmodule

// File: rtl/rxtick_seq.sv
module rxtick_seq
   import rxtick_pkg::*;
#(
   parameter int unsigned DIV_LO  = 10,
   parameter int unsigned DIV_HI  = 14,
   parameter int unsigned LOG_MAX = 3,
   parameter int unsigned STUP_HALVES [RATE_N] = '{1793, 1025, 1025, 641}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_sel,
   input  logic [1:0] rate_sel,
   input  logic       enable_in,
   input  logic       demod_in,
   output logic       base_tick,
   output logic       ext_tick,
   output logic [1:0] state_o,
   output logic       data_gate
);
   seq_state_t        st_w;
   logic              run_w;
   logic              cfg_mode_w;
   logic [RATE_W-1:0] cfg_rate_w;

   rxtick_seq_fsm #(
      .DIV_LO      (DIV_LO),
      .DIV_HI      (DIV_HI),
      .STUP_HALVES (STUP_HALVES)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_in (enable_in),
      .demod_in  (demod_in),
      .mode_sel  (mode_sel),
      .rate_sel  (rate_sel),
      .state     (st_w),
      .run       (run_w),
      .cfg_mode  (cfg_mode_w),
      .cfg_rate  (cfg_rate_w)
   );

   rxtick_base_div #(
      .DIV_LO (DIV_LO),
      .DIV_HI (DIV_HI)
   ) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_w),
      .sel_hi (cfg_mode_w),
      .tick   (base_tick)
   );

   rxtick_ext_div #(
      .LOG_MAX (LOG_MAX)
   ) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_w),
      .rate      (cfg_rate_w),
      .base_tick (base_tick),
      .tick      (ext_tick)
   );

   assign state_o   = st_w;
   assign data_gate = (st_w == ST_OPEN);

endmodule

// File: rtl/rxtick_seq_chk.sv
module rxtick_seq_chk
   import rxtick_pkg::*;
#(
   parameter int unsigned DIV_LO  = 10,
   parameter int unsigned DIV_HI  = 14,
   parameter int unsigned STUP_HALVES [RATE_N] = '{1793, 1025, 1025, 641}
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable_in,
   input logic              demod_in,
   input logic              base_tick,
   input logic              ext_tick,
   input logic [1:0]        state_o,
   input logic              data_gate,
   input logic              cfg_mode,
   input logic [RATE_W-1:0] cfg_rate
);
   logic [15:0] gap;
   logic [15:0] stup_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap      <= '0;
         stup_len <= '0;
      end else begin
         if (state_o == 2'd0 || base_tick) gap <= '0;
         else                              gap <= gap + 1'b1;
         if (state_o == 2'd1) stup_len <= stup_len + 1'b1;
         else                 stup_len <= '0;
      end
   end

   int unsigned exp_div;
   int unsigned exp_stup;
   always_comb begin
      exp_div  = cfg_mode ? DIV_HI : DIV_LO;
      exp_stup = (STUP_HALVES[cfg_rate] * exp_div) / 2;
   end

   a_r1_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0) |-> (!base_tick && !ext_tick && !data_gate));

   a_r2_base_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      base_tick |-> (32'(gap) == exp_div - 1));

   a_r3_ext_on_base: assert property (@(posedge clk) disable iff (!rst_n)
      ext_tick |-> base_tick);

   a_r5_startup_len: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && $past(state_o) == 2'd1) |-> (32'(stup_len) == exp_stup));

   a_r6_gate_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_gate) |-> ($past(demod_in) == 1'b0 && $past(demod_in, 2) == 1'b1));

   a_r7_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (data_gate && enable_in) |=> data_gate);

   a_r8_drop_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_in |=> (state_o == 2'd0));

endmodule

bind rxtick_seq rxtick_seq_chk #(
   .DIV_LO      (DIV_LO),
   .DIV_HI      (DIV_HI),
   .STUP_HALVES (STUP_HALVES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable_in (enable_in),
   .demod_in  (demod_in),
   .base_tick (base_tick),
   .ext_tick  (ext_tick),
   .state_o   (state_o),
   .data_gate (data_gate),
   .cfg_mode  (cfg_mode_w),
   .cfg_rate  (cfg_rate_w)
);

// File: tb/rxtick_seq_test.sv
`timescale 1ns/1ps
module rxtick_seq_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       mode_sel;
   logic [1:0] rate_sel;
   logic       enable_in;
   logic       demod_in;
   logic       base_tick;
   logic       ext_tick;
   logic [1:0] state_o;
   logic       data_gate;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rxtick_seq uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .rate_sel  (rate_sel),
      .enable_in (enable_in),
      .demod_in  (demod_in),
      .base_tick (base_tick),
      .ext_tick  (ext_tick),
      .state_o   (state_o),
      .data_gate (data_gate)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Starts a session and checks every cycle of start-up plus the first armed cycle.
   task automatic run_session(input bit mode, input bit [1:0] rate, input int div,
                              input int mult, input int stup, input bit flip,
                              input string tag);
      int bad_b = 0;
      int bad_e = 0;
      int bad_s = 0;
      demod_in  = 1'b0;
      mode_sel  = mode;
      rate_sel  = rate;
      enable_in = 1'b1;
      step();
      for (int j = 0; j <= stup; j++) begin
         if (int'(base_tick) != int'(((j + 1) % div) == 0)) bad_b++;
         if (int'(ext_tick) != int'(((j + 1) % (div * mult)) == 0)) bad_e++;
         if (int'(state_o) != ((j < stup) ? 1 : 2)) bad_s++;
         if (flip && j == 2) begin
            mode_sel = ~mode;
            rate_sel = ~rate;
         end
         if (j < stup) step();
      end
      check({tag, " R2 base tick mismatches"}, bad_b, 0);
      check({tag, " R3 ext tick mismatches"}, bad_e, 0);
      check({tag, " R5 start-up length mismatches"}, bad_s, 0);
      check({tag, " R5 gate closed when armed"}, int'(data_gate), 0);
   endtask

   task automatic drop_enable(input string tag);
      enable_in = 1'b0;
      step();
      check({tag, " R8 state after drop"}, int'(state_o), 0);
      check({tag, " R8 gate after drop"}, int'(data_gate), 0);
   endtask

   task automatic t_reset();
      int ticks = 0;
      check("R1 reset state", int'(state_o), 0);
      check("R1 reset gate", int'(data_gate), 0);
      for (int i = 0; i < 40; i++) begin
         demod_in = i[0];
         mode_sel = i[2];
         rate_sel = i[4:3];
         step();
         ticks += int'(base_tick) + int'(ext_tick) + int'(data_gate);
      end
      check("R1 no activity in sleep", ticks, 0);
   endtask

   task automatic t_open_gate();
      int closed = 0;
      run_session(1'b0, 2'd0, 10, 8, 8965, 1'b0, "m0r0");
      demod_in = 1'b1;
      step();
      check("R6 armed before fall", int'(state_o), 2);
      check("R6 gate before fall", int'(data_gate), 0);
      demod_in = 1'b0;
      step();
      check("R6 state after fall", int'(state_o), 3);
      check("R6 gate after fall", int'(data_gate), 1);
      for (int i = 0; i < 30; i++) begin
         demod_in = i[1];
         step();
         if (!data_gate) closed++;
      end
      check("R7 gate held open", closed, 0);
      drop_enable("m0r0");
   endtask

   task automatic t_ranges();
      run_session(1'b1, 2'd1, 14, 4, 7175, 1'b0, "m1r1 R4");
      drop_enable("m1r1");
      run_session(1'b1, 2'd2, 14, 2, 7175, 1'b0, "m1r2 R4");
      drop_enable("m1r2");
      run_session(1'b1, 2'd0, 14, 8, 12551, 1'b0, "m1r0");
      drop_enable("m1r0");
   endtask

   task automatic t_mid_change();
      run_session(1'b0, 2'd3, 10, 1, 3205, 1'b1, "R9 frozen cfg");
      drop_enable("R9");
   endtask

   task automatic t_fall_in_startup();
      int opened = 0;
      demod_in  = 1'b0;
      mode_sel  = 1'b0;
      rate_sel  = 2'd3;
      enable_in = 1'b1;
      step();
      for (int j = 0; j < 3205; j++) begin
         if (j == 100) demod_in = 1'b1;
         if (j == 105) demod_in = 1'b0;
         if (data_gate) opened++;
         step();
      end
      check("R10 armed after start-up", int'(state_o), 2);
      for (int i = 0; i < 20; i++) begin
         if (data_gate) opened++;
         step();
      end
      check("R10 gate stays closed", opened, 0);
      drop_enable("R10");
   endtask

   task automatic t_restart();
      mode_sel  = 1'b1;
      rate_sel  = 2'd0;
      enable_in = 1'b1;
      step();
      for (int i = 0; i < 57; i++) step();
      drop_enable("restart");
      run_session(1'b0, 2'd3, 10, 1, 3205, 1'b0, "R8 restart");
      drop_enable("R8 restart end");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      rst_n     = 1'b0;
      mode_sel  = 1'b0;
      rate_sel  = 2'd0;
      enable_in = 1'b0;
      demod_in  = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_open_gate();
      t_ranges();
      t_mid_change();
      t_fall_in_startup();
      t_restart();
      report();
   end

endmodule